// File: doc/BRIEF.md
# Double-Buffered Colour Matrix Converter

The block converts a stream of three-channel pixels through a 3x4 affine matrix: each output channel is a weighted sum of the three input channels plus a per-row offset, rounded to nearest and clamped to the unsigned channel range. Coefficients sit in two banks that a host fills through a small register bus. A mode register picks pass-through, bank A or bank B.

A mode write only becomes pending. The pending mode is adopted on the next frame-start strobe, so a frame is never converted with a mix of two banks. The host updates without tearing in three steps. It first reads the active mode through a debug index/data pair. It then rewrites the bank that is not in use. Finally it requests that bank and waits for the frame boundary.

The pixel path is a three-stage pipeline with one global stall. `in_ready` equals `out_ready`. When `out_ready` is low, no stage moves, no pixel is accepted and the output holds its value. A transfer takes place on any clock edge where valid and ready are both high. The producer may hold or change `in_pix` freely while it is not being accepted.

Top module: `csc_dual_bank`

## Requirements
- R1: After reset, `out_valid` is 0, all coefficients of both banks read 0, the requested mode reads 0 and the active mode is pass-through (mode 0).
- R2: While the active mode is any value other than 4 or 5, every output pixel equals its input pixel, channel for channel.
- R3: In a bank mode, output channel r equals round(sum over j of c[r][j]*x[j] / 2^13 + c[r][3] / 2^(CW-DW)). The coefficients c[r][0..2] are signed 16-bit values with 13 fraction bits, so 0x2000 is a gain of 1.0. The offset c[r][3] is signed 16-bit in units of 2^-(CW-DW) of an output LSB, so 0x8000 is minus half of full scale. Channel 0 sits in the low DW bits of a pixel.
- R4: Rounding is to nearest, and an exact half rounds up (toward +infinity).
- R5: Results below 0 give 0, and results above 2^DW-1 give 2^DW-1.
- R6: Bank A coefficients sit at register addresses 0..11 and bank B at 16..27, both in row order (row r, column j at base+4r+j). Each one reads back as written.
- R7: Mode 4 selects bank A and mode 5 selects bank B. A mode written at address 12 takes effect only at the next `frame_start` pulse, so pixels accepted before that pulse use the previous mode.
- R8: When the mode is written more than once before a `frame_start`, only the last value is adopted. A `frame_start` with no write since the previous one leaves the active mode unchanged.
- R9: Address 12 reads back the last requested mode, and address 13 holds a debug index. Address 14 returns the active mode in bits [2:0] while the index is 9, and returns 0 for any other index.
- R10: With `out_ready` high, a pixel accepted at a clock edge appears on `out_valid`/`out_pix` three edges later. `in_ready` follows `out_ready`, and while `out_ready` is low the output pixel and `out_valid` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 3*DW | Input pixel, channel 0 in low bits |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready; low stalls the whole pipeline |
| out_pix | output | 3*DW | Output pixel, channel 0 in low bits |
| frame_start | input | 1 | One-cycle frame boundary strobe; adopts a pending mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register address for write and read |
| reg_wdata | input | CW | Register write data |
| reg_rdata | output | CW | Register read data for reg_addr (combinational) |

## Verification
Some rules are checked by the assertions on every cycle. The active mode moves only on a frame-start pulse, and a pulse with nothing pending leaves it alone. A stalled output holds its value. A pixel accepted with ready held high emerges three cycles later. The arithmetic cannot be checked that way: the matrix values, the rounding of ties, saturation at both ends, the bank address layout and the debug readback are shown only by the bench's sweeps. Those sweeps compare against sums the bench computes itself. They also show that pixels sent after a mode request but before the boundary still use the old bank, and that the last of several requests wins.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int N_ROW  = 3;
  localparam int N_COL  = 4;
  localparam int N_COEF = N_ROW * N_COL;

  localparam logic [2:0] MODE_PASS   = 3'd0;
  localparam logic [2:0] MODE_BANK_A = 3'd4;
  localparam logic [2:0] MODE_BANK_B = 3'd5;

  localparam int ADDR_MODE     = 12;
  localparam int ADDR_DBG_IDX  = 13;
  localparam int ADDR_DBG_DATA = 14;
  localparam int BANK_B_BASE   = 16;
  localparam int DBG_SEL_MODE  = 9;
endpackage

// File: rtl/csc_regs.sv
module csc_regs
  import csc_pkg::*;
#(
  parameter int CW  = 16,
  parameter int RAW = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [RAW-1:0]                 addr,
  input  logic [CW-1:0]                  wdata,
  output logic [CW-1:0]                  rdata,
  input  logic                           frame_start,
  output logic [N_COEF-1:0][CW-1:0]      bank_a,
  output logic [N_COEF-1:0][CW-1:0]      bank_b,
  output logic [2:0]                     active_mode
);
  localparam int IDX_W = 8;

  logic [2:0]       mode_req;
  logic             pend;
  logic [IDX_W-1:0] dbg_idx;

  // coefficient storage, one register per bank and position
  for (genvar i = 0; i < N_COEF; i++) begin : g_coef
    localparam logic [RAW-1:0] A_ADR = RAW'(i);
    localparam logic [RAW-1:0] B_ADR = RAW'(BANK_B_BASE + i);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_a[i] <= '0;
        bank_b[i] <= '0;
      end else if (we) begin
        if (addr == A_ADR) bank_a[i] <= wdata;
        if (addr == B_ADR) bank_b[i] <= wdata;
      end
    end
  end

  // mode request is held pending until a frame boundary
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_req    <= MODE_PASS;
      pend        <= 1'b0;
      active_mode <= MODE_PASS;
      dbg_idx     <= '0;
    end else begin
      if (we && addr == RAW'(ADDR_MODE)) begin
        mode_req <= wdata[2:0];
        pend     <= 1'b1;
      end else if (frame_start) begin
        pend <= 1'b0;
      end
      if (frame_start && pend) active_mode <= mode_req;
      if (we && addr == RAW'(ADDR_DBG_IDX)) dbg_idx <= wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_COEF; i++) begin
      if (addr == RAW'(i))               rdata = bank_a[i];
      if (addr == RAW'(BANK_B_BASE + i)) rdata = bank_b[i];
    end
    if (addr == RAW'(ADDR_MODE))    rdata = CW'(mode_req);
    if (addr == RAW'(ADDR_DBG_IDX)) rdata = CW'(dbg_idx);
    if (addr == RAW'(ADDR_DBG_DATA))
      rdata = (dbg_idx == IDX_W'(DBG_SEL_MODE)) ? CW'(active_mode) : '0;
  end

  AST_MODE_ONLY_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(active_mode)); // R7
  AST_IDLE_FRAME_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !pend) |=> $stable(active_mode)); // R8
  AST_LAST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && pend) |=> active_mode == $past(mode_req)); // R8
endmodule

// File: rtl/csc_row.sv
module csc_row
  import csc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 16,
  parameter int FRAC = 13
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [N_ROW-1:0][DW-1:0] x,
  input  logic [N_COL-1:0][CW-1:0] coef,
  input  logic                    bypass,
  input  logic [DW-1:0]           pass_val,
  output logic [DW-1:0]           y
);
  localparam int ACC_W  = CW + DW + 3;
  localparam int OFS_SH = FRAC - (CW - DW);
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << DW) - 1);

  logic signed [ACC_W-1:0] acc_d, acc_q, rnd, shf;
  logic                    byp_q;
  logic [DW-1:0]           pass_q, sat;

  // stage 2 input: full precision sum of products plus offset
  always_comb begin
    logic signed [ACC_W-1:0] cx, xx, ofs;
    acc_d = '0;
    for (int j = 0; j < N_ROW; j++) begin
      cx = {{(ACC_W-CW){coef[j][CW-1]}}, coef[j]};
      xx = {{(ACC_W-DW){1'b0}}, x[j]};
      acc_d = acc_d + cx * xx;
    end
    ofs = {{(ACC_W-CW){coef[N_COL-1][CW-1]}}, coef[N_COL-1]};
    acc_d = acc_d + (ofs <<< OFS_SH);
  end

  // stage 3 input: round half up, then clamp
  always_comb begin
    rnd = acc_q + RND;
    shf = rnd >>> FRAC;
    if (shf < 0)         sat = '0;
    else if (shf > MAXV) sat = MAXV[DW-1:0];
    else                 sat = shf[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      byp_q  <= 1'b0;
      pass_q <= '0;
      y      <= '0;
    end else if (en) begin
      acc_q  <= acc_d;
      byp_q  <= bypass;
      pass_q <= pass_val;
      y      <= byp_q ? pass_q : sat;
    end
  end

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(y)); // R10
endmodule

// File: rtl/csc_dual_bank.sv
module csc_dual_bank
  import csc_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CW   = 16,
  parameter int FRAC = 13,
  parameter int RAW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3*DW-1:0]   in_pix,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3*DW-1:0]   out_pix,
  input  logic              frame_start,
  input  logic              reg_we,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata
);
  logic [N_COEF-1:0][CW-1:0] bank_a, bank_b, s1_coef;
  logic [2:0]                active_mode;
  logic                      en, v1, v2, v3, s1_byp;
  logic [N_ROW-1:0][DW-1:0]  s1_pix;
  logic [N_ROW-1:0][DW-1:0]  y;

  assign en       = out_ready;
  assign in_ready = out_ready;

  csc_regs #(.CW(CW), .RAW(RAW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .frame_start(frame_start),
    .bank_a(bank_a), .bank_b(bank_b), .active_mode(active_mode)
  );

  // stage 1: capture pixel with a snapshot of the coefficients in force
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      s1_pix  <= '0;
      s1_coef <= '0;
      s1_byp  <= 1'b1;
    end else if (en) begin
      v1 <= in_valid && in_ready;
      v2 <= v1;
      v3 <= v2;
      s1_pix <= in_pix;
      s1_byp <= !(active_mode == MODE_BANK_A || active_mode == MODE_BANK_B);
      s1_coef <= (active_mode == MODE_BANK_B) ? bank_b : bank_a;
    end
  end

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    csc_row #(.DW(DW), .CW(CW), .FRAC(FRAC)) u_row (
      .clk(clk), .rst_n(rst_n), .en(en), .x(s1_pix),
      .coef(s1_coef[r*N_COL +: N_COL]), .bypass(s1_byp),
      .pass_val(s1_pix[r]), .y(y[r])
    );
  end

  assign out_valid = v3;
  assign out_pix   = y;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R10
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && $past(out_ready) && $past(in_valid && in_ready, 2)) |=> out_valid); // R10
  AST_NO_ACCEPT_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> $stable(out_valid)); // R10
endmodule

// File: tb/sim_csc_dual_bank.sv
module sim_csc_dual_bank;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8, CW = 16, FRAC = 13, RAW = 5;
  localparam int MAXV = (1 << DW) - 1;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, frame_start = 0;
  logic [3*DW-1:0] in_pix = '0, out_pix;
  logic reg_we = 0;
  logic [RAW-1:0] reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0, reg_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  csc_dual_bank #(.DW(DW), .CW(CW), .FRAC(FRAC), .RAW(RAW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .frame_start(frame_start), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int n_cmp = 0, n_bad = 0, ncyc = 0;
  int bank [2][12];
  int mode_act = 0, mode_req = 0;
  bit pend = 0;
  logic [3*DW-1:0] exp_q[$];
  string tag_q[$];
  int stamp_q[$];
  bit lat_q[$];
  string cur_tag = "R2";
  bit lat_flag = 0, hold_pend = 0;
  logic [3*DW-1:0] hold_val;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
    end
  endtask

  function automatic int exp_ch(int m, int r, int x0, int x1, int x2);
    longint acc;
    int b, xs[3];
    xs[0] = x0; xs[1] = x1; xs[2] = x2;
    if (m != 4 && m != 5) return xs[r];
    b = (m == 4) ? 0 : 1;
    acc = longint'(bank[b][4*r]) * x0 + longint'(bank[b][4*r+1]) * x1 +
          longint'(bank[b][4*r+2]) * x2 + longint'(bank[b][4*r+3]) * 32;
    acc = (acc + 4096) >>> 13;
    if (acc < 0) return 0;
    if (acc > MAXV) return MAXV;
    return int'(acc);
  endfunction

  // one cycle: drive at negedge, check outputs that leave at the next edge
  task automatic cyc(input bit v, input int x0, input int x1, input int x2,
                     input bit rdy, input bit fs, input bit we,
                     input int adr, input int wd);
    logic [3*DW-1:0] e;
    @(negedge clk);
    ncyc++;
    out_ready = rdy;
    if (hold_pend) chk(out_valid && out_pix == hold_val, "R10 hold", out_pix, hold_val);
    hold_pend = out_valid && !rdy;
    hold_val  = out_pix;
    if (out_valid && rdy) begin
      if (exp_q.size() == 0) chk(0, "R10 spurious", out_pix, 0);
      else begin
        e = exp_q.pop_front();
        chk(out_pix == e, tag_q.pop_front(), out_pix, e);
        if (lat_q.pop_front()) chk(ncyc - stamp_q[0] == 3, "R10 latency", ncyc - stamp_q[0], 3);
        void'(stamp_q.pop_front());
      end
    end
    in_valid = v;
    in_pix = {DW'(x2), DW'(x1), DW'(x0)};
    frame_start = fs;
    reg_we = we;
    reg_addr = RAW'(adr);
    reg_wdata = CW'(wd);
    if (v && rdy) begin
      exp_q.push_back({DW'(exp_ch(mode_act, 2, x0, x1, x2)),
                       DW'(exp_ch(mode_act, 1, x0, x1, x2)),
                       DW'(exp_ch(mode_act, 0, x0, x1, x2))});
      tag_q.push_back(cur_tag);
      stamp_q.push_back(ncyc);
      lat_q.push_back(lat_flag);
    end
    if (we && adr < 12) bank[0][adr] = int'($signed(CW'(wd)));
    if (we && adr >= 16 && adr < 28) bank[1][adr-16] = int'($signed(CW'(wd)));
    if (fs && pend) begin mode_act = mode_req; pend = 0; end
    if (we && adr == 12) begin mode_req = wd & 7; pend = 1; end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic wr(input int adr, input int wd);
    cyc(0, 0, 0, 0, 1, 0, 1, adr, wd);
  endtask
  task automatic fstart();
    cyc(0, 0, 0, 0, 1, 1, 0, 0, 0);
  endtask
  task automatic rd_chk(input int adr, input int expv, input string tag);
    cyc(0, 0, 0, 0, 1, 0, 0, adr, 0);
    #1 chk(reg_rdata == CW'(expv), tag, reg_rdata, expv);
  endtask
  task automatic drain();
    for (int i = 0; i < 50 && exp_q.size() > 0; i++) idle(1);
    chk(exp_q.size() == 0, "R10 drain", exp_q.size(), 0);
  endtask
  task automatic sweep(input int n, input bit stall);
    for (int i = 0; i < n; i++)
      cyc(1, i & MAXV, (MAXV - i) & MAXV, (i * 37 + 11) & MAXV,
          stall ? (((i * 7) % 5) < 3) : 1'b1, 0, 0, 0, 0);
    drain();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    foreach (bank[b, i]) bank[b][i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    #1 chk(out_valid == 0, "R1 out_valid", out_valid, 0);
    rd_chk(0, 0, "R1 bankA");
    rd_chk(16, 0, "R1 bankB");
    rd_chk(12, 0, "R1 mode req");
    wr(13, 9);
    rd_chk(14, 0, "R1 active mode");

    // R2 pass-through after reset
    cur_tag = "R2"; sweep(64, 0);

    // R6 program bank A: row0 gain 0.5, row1 identity+1LSB, row2 mixed
    wr(0, 16'h1000); wr(1, 0); wr(2, 0); wr(3, 0);
    wr(4, 0); wr(5, 16'h2000); wr(6, 0); wr(7, 16'h0100);
    wr(8, 16'h0AAB); wr(9, 16'hF000); wr(10, 16'h0AAB); wr(11, 0);
    rd_chk(5, 16'h2000, "R6 bankA readback");
    rd_chk(9, 16'hF000, "R6 bankA readback");
    wr(12, 4);
    cur_tag = "R7 before frame"; sweep(8, 0);
    fstart();
    rd_chk(14, 4, "R9 active mode A");
    // R10 latency on a single pixel, then R4 ties and R5 clamp
    lat_flag = 1; cur_tag = "R10";
    cyc(1, 5, 6, 7, 1, 0, 0, 0, 0);
    lat_flag = 0; drain();
    cur_tag = "R4"; cyc(1, 3, 0, 0, 1, 0, 0, 0, 0); cyc(1, 1, 0, 0, 1, 0, 0, 0, 0);
    chk(exp_ch(4, 0, 3, 0, 0) == 2, "R4 model", exp_ch(4, 0, 3, 0, 0), 2);
    cur_tag = "R5"; cyc(1, 0, 255, 0, 1, 0, 0, 0, 0); cyc(1, 0, 255, 0, 1, 0, 0, 0, 0);
    drain();
    cur_tag = "R3"; sweep(256, 0);

    // bank B: row0 2x minus half scale, row1 takes x2, row2 x0+x1
    wr(16, 16'h4000); wr(17, 0); wr(18, 0); wr(19, 16'h8000);
    wr(20, 0); wr(21, 0); wr(22, 16'h2000); wr(23, 0);
    wr(24, 16'h2000); wr(25, 16'h2000); wr(26, 0); wr(27, 0);
    rd_chk(19, 16'h8000, "R6 bankB readback");
    wr(12, 0); wr(12, 5);
    cur_tag = "R7 old bank"; sweep(16, 0);
    rd_chk(14, 4, "R7 mode unchanged");
    fstart();
    rd_chk(14, 5, "R8 last request");
    fstart();
    rd_chk(14, 5, "R8 idle frame");
    cur_tag = "R5"; sweep(256, 1);
    cur_tag = "R10 stall"; sweep(64, 1);

    // R2 unknown mode passes through
    wr(12, 7); fstart();
    cur_tag = "R2"; sweep(32, 0);
    rd_chk(12, 7, "R9 requested mode");
    wr(13, 3);
    rd_chk(14, 0, "R9 other index");
    rd_chk(13, 3, "R9 index readback");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule